// File: doc/BRIEF.md
# SPI Parallel I/O Expander

This block is an SPI mode 0 peripheral that turns four serial wires into a bank of parallel outputs and a bank of parallel inputs. The controller shifts output data in on MOSI, most significant bit first. The new values reach the output pins only when the active-low select returns high, so a partly shifted word never shows on the pins. The input pins are sampled continuously while the peripheral is deselected. Their value freezes when select falls, and the bits then leave on MISO, top bit first.

All SPI lines are sampled by a faster system clock and resynchronised, so the block works inside a single clock domain. MISO appears as a data bit plus an output-enable flag, and a pad cell or an upper level turns these into a tri-state driver. The output and input widths are parameters and may differ. A transfer then runs for as many bits as the longer side needs.

Top module: `spi_io_expander`

## Requirements
- R1: After reset, every output pin reads 0 and the MISO enable is 0.
- R2: Each SCK rising edge shifts the MOSI level into the output chain. After at least OUT_W bits, output pin OUT_W-1 holds the earliest of the last OUT_W bits sent, and pin 0 holds the last bit sent.
- R3: The output pins do not change while select is low, whatever SCK and MOSI do.
- R4: On each select rising edge, the output pins take the last OUT_W bits shifted in.
- R5: SCK edges while select is high still shift the output chain, but the pins keep their value until the next select rising edge.
- R6: While select is high the input chain reloads from the input pins. Changes on the input pins after select falls do not affect the bits sent on MISO.
- R7: The MISO enable is 1 only while select is low, and 0 otherwise.
- R8: When select falls, MISO presents input bit IN_W-1 before the first SCK rising edge. After the k-th SCK rising edge it presents input bit IN_W-1-k. MISO changes only after a rising edge, never before it.
- R9: A transfer longer than either chain is accepted. MISO bits past IN_W are don't-care, and the outputs take the last OUT_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the SPI lines |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | SPI clock, idle low |
| cs_ni | input | 1 | Active-low select |
| mosi_i | input | 1 | Serial data from the controller |
| miso_o | output | 1 | Serial data to the controller |
| miso_oe_o | output | 1 | Enable for the MISO driver (1 = drive) |
| par_in_i | input | IN_W | Parallel input pins |
| par_out_o | output | OUT_W | Latched parallel output pins |

## Verification
Transfers use alternating, sparse and dense output words paired with different input words. A bit-order swap or an off-by-one in either chain therefore shows up as a mismatch. A 12-bit transfer checks that the outputs keep only the last eight bits and that extra MISO bits are tolerated. Clocking while deselected, followed by a select pulse with no clocks, separates latching on the select edge from shifting on SCK. Changing the input pins in the middle of a transfer shows whether the capture froze at the select fall.

// File: rtl/spi_xp_pkg.sv
package spi_xp_pkg;
  typedef struct packed {
    logic sck;
    logic cs_n;
    logic mosi;
  } spi_lines_t;

  localparam spi_lines_t LINES_IDLE = '{sck: 1'b0, cs_n: 1'b1, mosi: 1'b0};
endpackage

// File: rtl/spi_xp_sync.sv
module spi_xp_sync
  import spi_xp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  spi_lines_t d_i,
  output spi_lines_t q_o,
  output logic       sck_rise_o,
  output logic       cs_rise_o
);
  spi_lines_t s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= LINES_IDLE;
      s2_q <= LINES_IDLE;
      s3_q <= LINES_IDLE;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign q_o        = s2_q;
  assign sck_rise_o = s2_q.sck & ~s3_q.sck;
  assign cs_rise_o  = s2_q.cs_n & ~s3_q.cs_n;
endmodule

// File: rtl/spi_xp_out_chain.sv
module spi_xp_out_chain #(
  parameter int OUT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sck_rise_i,
  input  logic             cs_rise_i,
  input  logic             din_i,
  output logic [OUT_W-1:0] par_o
);
  logic [OUT_W-1:0] sh_q, par_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      par_q <= '0;
    end else begin
      if (sck_rise_i) sh_q <= {sh_q[OUT_W-2:0], din_i};
      if (cs_rise_i)  par_q <= sh_q;
    end
  end

  assign par_o = par_q;

  // R2
  shift_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_rise_i |=> sh_q[0] == $past(din_i));
  // R3
  hold_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_rise_i |=> $stable(par_q));
endmodule

// File: rtl/spi_xp_in_chain.sv
module spi_xp_in_chain #(
  parameter int IN_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            sck_rise_i,
  input  logic [IN_W-1:0] par_i,
  output logic            sout_o
);
  logic [IN_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         sh_q <= '0;
    else if (load_i)     sh_q <= par_i;
    else if (sck_rise_i) sh_q <= {sh_q[IN_W-2:0], 1'b0};
  end

  assign sout_o = sh_q[IN_W-1];

  // R6
  load_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> sh_q == $past(par_i));
  // R8
  advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && sck_rise_i) |=> sout_o == $past(sh_q[IN_W-2]));
  // R8
  freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !sck_rise_i) |=> $stable(sh_q));
endmodule

// File: rtl/spi_io_expander.sv
module spi_io_expander
  import spi_xp_pkg::*;
#(
  parameter int OUT_W = 8,
  parameter int IN_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sck_i,
  input  logic             cs_ni,
  input  logic             mosi_i,
  output logic             miso_o,
  output logic             miso_oe_o,
  input  logic [IN_W-1:0]  par_in_i,
  output logic [OUT_W-1:0] par_out_o
);
  spi_lines_t raw, syn;
  logic sck_rise, cs_rise, in_bit;

  assign raw = '{sck: sck_i, cs_n: cs_ni, mosi: mosi_i};

  spi_xp_sync u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .d_i        (raw),
    .q_o        (syn),
    .sck_rise_o (sck_rise),
    .cs_rise_o  (cs_rise)
  );

  spi_xp_out_chain #(.OUT_W(OUT_W)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sck_rise_i (sck_rise),
    .cs_rise_i  (cs_rise),
    .din_i      (syn.mosi),
    .par_o      (par_out_o)
  );

  spi_xp_in_chain #(.IN_W(IN_W)) u_in (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (syn.cs_n),
    .sck_rise_i (sck_rise),
    .par_i      (par_in_i),
    .sout_o     (in_bit)
  );

  assign miso_oe_o = ~syn.cs_n;
  assign miso_o    = miso_oe_o & in_bit;

  // R7
  oe_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni) && $past(cs_ni, 2)) |-> !miso_oe_o);
endmodule

// File: tb/sim_spi_io_expander.sv
module sim_spi_io_expander;
  localparam int OUT_W = 8;
  localparam int IN_W  = 8;
  localparam int HALF  = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sck_i = 1'b0;
  logic cs_ni = 1'b1;
  logic mosi_i = 1'b0;
  logic [IN_W-1:0] par_in_i = '0;
  logic miso_o, miso_oe_o;
  logic [OUT_W-1:0] par_out_o;

  int total = 0;
  int bad = 0;
  logic miso_q[$];
  logic [OUT_W-1:0] out_q[$];

  always #2 clk = ~clk;

  spi_io_expander #(.OUT_W(OUT_W), .IN_W(IN_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sck_i(sck_i), .cs_ni(cs_ni),
    .mosi_i(mosi_i), .miso_o(miso_o), .miso_oe_o(miso_oe_o),
    .par_in_i(par_in_i), .par_out_o(par_out_o)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // monitor: MISO bits at each SCK rise while selected
  always @(posedge sck_i) begin
    if (!cs_ni && miso_q.size() > 0) begin
      logic e;
      e = miso_q.pop_front();
      chk(miso_oe_o === 1'b1 && miso_o === e, "R8 R6 miso bit", {miso_oe_o, miso_o}, {1'b1, e});
    end
  end

  // monitor: outputs after each select rise
  always @(posedge cs_ni) begin
    repeat (6) @(negedge clk);
    if (out_q.size() > 0) begin
      logic [OUT_W-1:0] e;
      e = out_q.pop_front();
      chk(par_out_o === e, "R4 R2 latched outputs", par_out_o, e);
    end
  end

  task automatic xfer(input logic [31:0] obits, input int n, input logic [IN_W-1:0] pin);
    logic [OUT_W-1:0] prev;
    par_in_i = pin;
    repeat (6) @(negedge clk);
    for (int i = 0; i < n && i < IN_W; i++) miso_q.push_back(pin[IN_W-1-i]);
    out_q.push_back(obits[OUT_W-1:0]);
    prev = par_out_o;
    cs_ni = 1'b0;
    repeat (4) @(negedge clk);
    par_in_i = ~pin;  // R6: must not reach MISO
    chk(miso_oe_o === 1'b1, "R7 enable when selected", miso_oe_o, 1);
    for (int i = n - 1; i >= 0; i--) begin
      mosi_i = obits[i];
      repeat (HALF) @(negedge clk);
      sck_i = 1'b1;
      repeat (HALF) @(negedge clk);
      sck_i = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    chk(par_out_o === prev, "R3 outputs held while selected", par_out_o, prev);
    cs_ni = 1'b1;
    repeat (10) @(negedge clk);
    chk(miso_oe_o === 1'b0, "R7 released when deselected", miso_oe_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [OUT_W-1:0] held;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    chk(par_out_o === '0, "R1 reset outputs", par_out_o, 0);
    chk(miso_oe_o === 1'b0, "R1 reset enable", miso_oe_o, 0);

    xfer(32'hA5, 8, 8'h3C);
    xfer(32'h01, 8, 8'h80);
    xfer(32'hFE, 8, 8'h7F);
    xfer(32'h96, 8, 8'hC3);
    // R9: longer transfer, last eight bits win
    xfer(32'hB2C, 12, 8'h5A);

    // R5: shifting while deselected
    held = par_out_o;
    for (int i = 7; i >= 0; i--) begin
      mosi_i = 8'h3D >> i;
      repeat (HALF) @(negedge clk);
      sck_i = 1'b1;
      repeat (HALF) @(negedge clk);
      chk(miso_oe_o === 1'b0, "R5 R7 no drive while deselected", miso_oe_o, 0);
      sck_i = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    chk(par_out_o === held, "R5 pins unchanged before select edge", par_out_o, held);
    out_q.push_back(8'h3D);
    cs_ni = 1'b0;
    repeat (6) @(negedge clk);
    cs_ni = 1'b1;
    repeat (12) @(negedge clk);

    chk(miso_q.size() == 0 && out_q.size() == 0, "R8 R4 all items consumed",
        miso_q.size() + out_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule